// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous memory array. A burst begins when either of two active-low address strobes is seen at a clock edge. One strobe belongs to a processor and only counts while the first chip enable (active low) is asserted. The other belongs to a cache controller and is always accepted. At that edge the block captures the full address input. The output then shows the captured address, with its low bits rewritten by a beat counter.

The beat counter starts at zero on every load. It steps once for each cycle in which the active-low advance input is asserted, and it holds otherwise. An order input picks how the counter maps onto the low address bits. Low selects a wrapping increment from the start offset. High selects the start offset XOR the beat number. Boards normally tie this input high by default, so interleaved order is the usual choice. The upper address bits never change during a burst. The output is decoded combinationally from the stored start address, the beat count and the order input.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets the address output to zero and the beat count to zero. Reset also wins over any strobe asserted in the same cycle.
- R2: When the processor strobe is low and the chip enable is low at a clock edge, the address input is loaded. The output equals that address from the next cycle.
- R3: When the cache-controller strobe is low at a clock edge, the address input is loaded whatever the chip enable is.
- R4: A low processor strobe while the chip enable is high, with the cache strobe high, leaves the output unchanged.
- R5: When both strobes are low in the same cycle, the processor strobe takes priority. A single load happens, and the output equals the address input on the next cycle.
- R6: Each clock edge with advance low and no load moves the beat count on by one. With advance high and no load, the output holds.
- R7: With the order input low (linear), the two low output bits equal (start + beat) mod 4. For a start of 1 this gives 1, 2, 3, 0.
- R8: With the order input high (interleaved), the two low output bits equal start XOR beat. For a start of 1 this gives 1, 0, 3, 2.
- R9: The output bits above the two low bits keep their loaded value for the whole burst, including when the low bits wrap. No carry passes upward.
- R10: A load in the same cycle as advance low restarts the beat count at zero. The load takes precedence over the advance.
- R11: A change of the order input during a burst re-maps the output in the same cycle, using the stored start and beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| cache_stb_n | input | 1 | Cache-controller address strobe, active low |
| chip_en_n | input | 1 | First chip enable, active low; qualifies the processor strobe only |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Address captured on a load |
| addr_out | output | ADDR_W | Current burst address to the array |

## Verification
The assertions check several rules on every cycle. A load from either strobe shows the captured address one cycle later and restarts the count. An idle cycle holds the output. The upper bits never move without a load. Each advance step matches the selected order. Some behaviours only the bench's scenarios can show: whole linear and interleaved sequences from odd start offsets, wrap-around without carry, the blocked processor strobe, simultaneous strobes, a mode flip mid-burst, and reset winning over a strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Where a new burst comes from in a given cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PROC  = 2'd1,
        SRC_CACHE = 2'd2
    } load_src_e;

    // Order selection as carried by the order input
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Raw strobe group sampled at the block edge (all active low)
    typedef struct packed {
        logic proc_n;
        logic cache_n;
        logic ce_n;
    } strobe_t;

    // Processor strobe first (when qualified), then cache strobe
    function automatic load_src_e pick_source(input strobe_t s);
        load_src_e r;
        if (!s.proc_n && !s.ce_n) begin
            r = SRC_PROC;
        end else if (!s.cache_n) begin
            r = SRC_CACHE;
        end else begin
            r = SRC_NONE;
        end
        return r;
    endfunction

endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
    import burst_seq_pkg::*;
(
    input  strobe_t   stb,
    output load_src_e src,
    output logic      load
);
    always_comb begin
        src  = pick_source(stb);
        load = (src != SRC_NONE);
    end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] beat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/bas_addr_reg.sv
module bas_addr_reg #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       addr_in,
    output logic [ADDR_W-CNT_W-1:0] hi_q,
    output logic [CNT_W-1:0]        start_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            start_q <= '0;
        end else if (load) begin
            hi_q    <= addr_in[ADDR_W-1:CNT_W];
            start_q <= addr_in[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  order_e           order,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] lo
);
    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] xor_lo;

    // Per-bit XOR for the interleaved order
    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_lo[b] = start[b] ^ beat[b];
    end

    // Wrapping add for the linear order
    assign lin_lo = start + beat;

    always_comb begin
        unique case (order)
            ORD_LINEAR:     lo = lin_lo;
            ORD_INTERLEAVE: lo = xor_lo;
            default:        lo = xor_lo;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_stb_n,
    input  logic              cache_stb_n,
    input  logic              chip_en_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - CNT_W;

    strobe_t          stb;
    load_src_e        src;
    logic             load;
    logic [CNT_W-1:0] beat_q;
    logic [HI_W-1:0]  hi_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] lo_map;
    order_e           order;

    assign stb.proc_n  = proc_stb_n;
    assign stb.cache_n = cache_stb_n;
    assign stb.ce_n    = chip_en_n;
    assign order       = order_e'(order_sel);

    bas_strobe_arb u_arb (
        .stb  (stb),
        .src  (src),
        .load (load)
    );

    bas_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (!adv_n),
        .beat_q (beat_q)
    );

    bas_addr_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_areg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_in (addr_in),
        .hi_q    (hi_q),
        .start_q (start_q)
    );

    bas_order_map #(.CNT_W(CNT_W)) u_map (
        .order (order),
        .start (start_q),
        .beat  (beat_q),
        .lo    (lo_map)
    );

    assign addr_out = {hi_q, lo_map};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              proc_stb_n,
    input logic              cache_stb_n,
    input logic              chip_en_n,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [CNT_W-1:0]  beat_q
);
    logic             ld;
    logic [CNT_W-1:0] lo;
    assign ld = !cache_stb_n || (!proc_stb_n && !chip_en_n);
    assign lo = addr_out[CNT_W-1:0];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && beat_q == '0)); // R1

    AST_PROC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && !chip_en_n) |=> addr_out == $past(addr_in)); // R2

    AST_CACHE_LOAD: assert property (@(posedge clk) disable iff (rst)
        !cache_stb_n |=> addr_out == $past(addr_in)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv_n) |=> (!$stable(order_sel) || $stable(addr_out))); // R6

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !ld |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])); // R9

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv_n && !order_sel) |=>
            (order_sel || lo == CNT_W'($past(lo) + 1'b1))); // R7

    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv_n && order_sel) |=>
            (!order_sel || (lo ^ $past(lo)) == ($past(beat_q) ^ CNT_W'($past(beat_q) + 1'b1)))); // R8

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        ld |=> beat_q == '0); // R10
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .proc_stb_n  (proc_stb_n),
    .cache_stb_n (cache_stb_n),
    .chip_en_n   (chip_en_n),
    .adv_n       (adv_n),
    .order_sel   (order_sel),
    .addr_in     (addr_in),
    .addr_out    (addr_out),
    .beat_q      (beat_q)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 19;
    localparam int NV         = 21;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              proc_stb_n = 1'b1;
    logic              cache_stb_n = 1'b1;
    logic              chip_en_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(2)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .proc_stb_n  (proc_stb_n),
        .cache_stb_n (cache_stb_n),
        .chip_en_n   (chip_en_n),
        .adv_n       (adv_n),
        .order_sel   (order_sel),
        .addr_in     (addr_in),
        .addr_out    (addr_out)
    );

    // Vector: {proc_n, cache_n, ce_n, adv_n, order, addr_in, expected, req}
    localparam logic [46:0] VEC [NV] = '{
        {1'b0,1'b1,1'b0,1'b1,1'b0,19'h12345,19'h12345,4'd2},  // R2 proc load
        {1'b1,1'b1,1'b1,1'b0,1'b0,19'h00000,19'h12346,4'd7},  // R7 linear 1->2
        {1'b1,1'b1,1'b1,1'b0,1'b0,19'h00000,19'h12347,4'd7},  // R7 2->3
        {1'b1,1'b1,1'b1,1'b0,1'b0,19'h00000,19'h12344,4'd9},  // R9 wrap, no carry
        {1'b1,1'b1,1'b1,1'b1,1'b0,19'h00000,19'h12344,4'd6},  // R6 hold
        {1'b1,1'b1,1'b1,1'b0,1'b0,19'h00000,19'h12345,4'd7},  // R7 back to start
        {1'b1,1'b0,1'b1,1'b1,1'b1,19'h2ABC1,19'h2ABC1,4'd3},  // R3 cache, ce off
        {1'b1,1'b1,1'b1,1'b0,1'b1,19'h00000,19'h2ABC0,4'd8},  // R8 1^1
        {1'b1,1'b1,1'b1,1'b0,1'b1,19'h00000,19'h2ABC3,4'd8},  // R8 1^2
        {1'b1,1'b1,1'b1,1'b0,1'b1,19'h00000,19'h2ABC2,4'd8},  // R8 1^3
        {1'b1,1'b1,1'b1,1'b0,1'b1,19'h00000,19'h2ABC1,4'd8},  // R8 count wraps
        {1'b0,1'b1,1'b1,1'b1,1'b1,19'h00007,19'h2ABC1,4'd4},  // R4 proc blocked
        {1'b0,1'b0,1'b0,1'b0,1'b0,19'h7FFFD,19'h7FFFD,4'd5},  // R5 both strobes
        {1'b1,1'b1,1'b1,1'b0,1'b0,19'h00000,19'h7FFFE,4'd7},  // R7 1->2
        {1'b1,1'b1,1'b1,1'b1,1'b1,19'h00000,19'h7FFFC,4'd11}, // R11 flip: 1^1
        {1'b1,1'b1,1'b1,1'b0,1'b0,19'h00000,19'h7FFFF,4'd7},  // R7 1+2
        {1'b1,1'b1,1'b1,1'b0,1'b0,19'h00000,19'h7FFFC,4'd9},  // R9 1+3 wraps
        {1'b1,1'b0,1'b0,1'b0,1'b0,19'h40002,19'h40002,4'd10}, // R10 load beats adv
        {1'b1,1'b1,1'b1,1'b0,1'b1,19'h00000,19'h40003,4'd8},  // R8 2^1
        {1'b1,1'b1,1'b1,1'b0,1'b1,19'h00000,19'h40000,4'd8},  // R8 2^2
        {1'b0,1'b1,1'b0,1'b0,1'b1,19'h0000E,19'h0000E,4'd10}  // R10 R2 proc mid-burst
    };

    task automatic check(input string req, input logic [ADDR_W-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic idle_inputs();
        proc_stb_n  = 1'b1;
        cache_stb_n = 1'b1;
        chip_en_n   = 1'b1;
        adv_n       = 1'b1;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [46:0]       v;
        logic [ADDR_W-1:0] exp;
        logic [3:0]        req;
        // R1: reset state
        repeat (2) @(posedge clk);
        #1 check("R1", '0);
        @(negedge clk) rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            @(negedge clk);
            {proc_stb_n, cache_stb_n, chip_en_n, adv_n, order_sel, addr_in} = v[46:23];
            exp = v[22:4];
            req = v[3:0];
            @(posedge clk);
            #1 check($sformatf("R%0d", req), exp);
        end

        // R1: reset wins over a simultaneous cache strobe
        @(negedge clk);
        rst = 1'b1; cache_stb_n = 1'b0; addr_in = 19'h55555;
        @(posedge clk);
        #1 check("R1", '0);
        @(negedge clk);
        rst = 1'b0; idle_inputs(); order_sel = 1'b0;
        // R6 R7: advance from the reset address
        @(negedge clk) adv_n = 1'b0;
        @(posedge clk);
        #1 check("R6", 19'h00001);
        @(negedge clk) idle_inputs();
        @(posedge clk);
        #1 check("R6", 19'h00001);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule